// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block sits behind a debug test access port and gives a host two scan chains into a processor core. The instruction chain carries a word-wide opcode plus a Ready flag; the data chain carries a data word plus a Ready flag and a retry-status flag. The TAP controller supplies one-cycle capture, shift and update strobes, a level that is high while the TAP rests in run-test/idle, a select for each chain and a direction qualifier that chooses between writing toward the core (write mode) and reading from it (read mode).

A host shifts an opcode into the instruction chain, then enters run-test/idle to make the block issue that opcode to the core as a one-cycle strobe with the opcode beside it. The core reports completion with a pulse. Data for the core is shifted in on the data chain in write mode and lands in a core-bound register; data from the core is placed by the core in an outgoing register, read back in read mode. Every scan reports Ready so the host can repeat a scan that arrived while the core was still busy, with no side effect from the rejected attempt. In write mode each new entry to run-test/idle re-issues the last opcode, so a stream of words can be fed to one repeating instruction.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset no issue strobe is given, the core-bound data register is zero, tdo is low and the shared Ready flag is set.
- R2: The instruction chain is DW+1 bits, shifted least significant bit first: a capture loads DW zero bits followed by the Ready bit at position DW, so the Ready value appears on tdo after DW shifts.
- R3: An update on the instruction chain loads the opcode register only if Ready was set at the last capture of that chain; otherwise the opcode register keeps its old value.
- R4: An issue strobe carries the loaded opcode, clears Ready, and Ready is set again by the core completion pulse; a capture while the core is busy reports Ready as 0.
- R5: An opcode issues once per entry into run-test/idle, however long the TAP stays there.
- R6: No opcode issues while the execution enable input is low.
- R7: In write mode an update on the data chain copies the DW shifted-in bits to the core-bound data register only if Ready was set at its capture; in read mode an update never changes that register.
- R8: The data chain is DW+2 bits, least significant bit first: DW data bits, a Ready bit at position DW and a retry-status bit at position DW+1. In read mode the capture loads the core's outgoing word, the full flag as Ready and the shared Ready flag as retry status; in write mode the data bits capture as zero and both flag bits carry the shared Ready flag.
- R9: A core write to the outgoing register sets the full flag; a read-mode capture of the data chain clears it.
- R10: With the data chain selected in write mode, each entry into run-test/idle re-issues the last loaded opcode while Ready is set.
- R11: No opcode issues when neither chain is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_itr | input | 1 | Instruction chain selected |
| sel_dtr | input | 1 | Data chain selected |
| mode_wr | input | 1 | 1: write toward core, 0: read from core |
| capture_dr | input | 1 | One-cycle capture strobe |
| shift_dr | input | 1 | Shift enable, one bit per cycle |
| update_dr | input | 1 | One-cycle update strobe |
| in_idle | input | 1 | High while the TAP is in run-test/idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| exec_en | input | 1 | Execution enable |
| core_done | input | 1 | Core completion pulse |
| core_wr_vld | input | 1 | Core writes its outgoing word |
| core_wr_data | input | DW | Outgoing word from the core |
| issue | output | 1 | One-cycle opcode issue strobe |
| issue_op | output | DW | Opcode issued |
| to_core_data | output | DW | Core-bound data register |

## Verification
The assertions assume the TAP strobes are mutually exclusive one-cycle pulses, that the chain selects and direction are stable through a scan, and that the core sends exactly one completion pulse per issue, never in the issue cycle. The bench drives every scan through one task that orders capture, shift and update on separate cycles and holds the selects fixed, and its core model answers each issue only after a programmable delay of at least three cycles, with the full flag written only together with completion.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [1:0] {
    CH_NONE = 2'd0,
    CH_ITR  = 2'd1,
    CH_DTR  = 2'd2
  } chain_e;

  function automatic chain_e pick_chain(input logic itr, input logic dtr);
    if (itr)      return CH_ITR;
    else if (dtr) return CH_DTR;
    else          return CH_NONE;
  endfunction
endpackage

// File: rtl/dxc_issue_ctrl.sv
module dxc_issue_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_idle,
  input  logic          exec_en,
  input  logic          chain_act,
  input  logic          itr_loaded,
  input  logic [DW-1:0] itr_op,
  input  logic          core_done,
  output logic          rdy,
  output logic          issue,
  output logic [DW-1:0] issue_op
);
  logic idle_q;
  logic fire;

  assign fire = in_idle && !idle_q && chain_act && itr_loaded && rdy && exec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q   <= 1'b0;
      rdy      <= 1'b1;
      issue    <= 1'b0;
      issue_op <= '0;
    end else begin
      idle_q <= in_idle;
      issue  <= fire;
      if (fire) issue_op <= itr_op;
      if (fire)           rdy <= 1'b0;
      else if (core_done) rdy <= 1'b1;
    end
  end

  p_single_issue_r5: assert property (@(posedge clk) disable iff (rst)
    issue |=> !issue);
  p_issue_clears_ready_r4: assert property (@(posedge clk) disable iff (rst)
    issue |-> !rdy);
  p_done_sets_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (!issue && $past(core_done)) |-> rdy);
  p_exec_gate_r6: assert property (@(posedge clk) disable iff (rst)
    issue |-> $past(exec_en));
  p_chain_gate_r11: assert property (@(posedge clk) disable iff (rst)
    issue |-> $past(chain_act));
endmodule

// File: rtl/dxc_itr_chain.sv
module dxc_itr_chain #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic          capture,
  input  logic          shift,
  input  logic          update,
  input  logic          tdi,
  input  logic          rdy,
  output logic          so,
  output logic [DW-1:0] itr_q,
  output logic          loaded
);
  localparam int LEN = DW + 1;

  logic [LEN-1:0] sr;
  logic           cap_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cap_rdy <= 1'b0;
      itr_q   <= '0;
      loaded  <= 1'b0;
    end else if (act) begin
      if (capture) begin
        sr      <= {rdy, {DW{1'b0}}};
        cap_rdy <= rdy;
      end else if (shift) begin
        sr <= {tdi, sr[LEN-1:1]};
      end
      if (update && cap_rdy) begin
        itr_q  <= sr[DW-1:0];
        loaded <= 1'b1;
      end
    end
  end

  assign so = sr[0];

  p_load_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (itr_q != $past(itr_q)) |-> $past(update && act && cap_rdy));
endmodule

// File: rtl/dxc_dtr_chain.sv
module dxc_dtr_chain #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic          mode_wr,
  input  logic          capture,
  input  logic          shift,
  input  logic          update,
  input  logic          tdi,
  input  logic          rdy,
  input  logic          core_wr_vld,
  input  logic [DW-1:0] core_wr_data,
  output logic          so,
  output logic [DW-1:0] to_core,
  output logic          full
);
  localparam int LEN = DW + 2;

  logic [LEN-1:0] sr;
  logic           cap_rdy;
  logic [DW-1:0]  from_core;
  logic           rd_cap;

  assign rd_cap = act && capture && !mode_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cap_rdy <= 1'b0;
      to_core <= '0;
    end else if (act) begin
      if (capture) begin
        cap_rdy <= rdy;
        if (mode_wr) sr <= {rdy, rdy, {DW{1'b0}}};
        else         sr <= {rdy, full, from_core};
      end else if (shift) begin
        sr <= {tdi, sr[LEN-1:1]};
      end
      if (update && mode_wr && cap_rdy) to_core <= sr[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      from_core <= '0;
      full      <= 1'b0;
    end else begin
      if (core_wr_vld) from_core <= core_wr_data;
      if (core_wr_vld) full <= 1'b1;
      else if (rd_cap) full <= 1'b0;
    end
  end

  assign so = sr[0];

  p_write_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (to_core != $past(to_core)) |-> $past(update && act && mode_wr && cap_rdy));
  p_full_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_cap && !core_wr_vld) |-> !full);
  p_full_set_r9: assert property (@(posedge clk) disable iff (rst)
    $past(core_wr_vld) |-> full);
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_itr,
  input  logic          sel_dtr,
  input  logic          mode_wr,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          in_idle,
  input  logic          tdi,
  output logic          tdo,
  input  logic          exec_en,
  input  logic          core_done,
  input  logic          core_wr_vld,
  input  logic [DW-1:0] core_wr_data,
  output logic          issue,
  output logic [DW-1:0] issue_op,
  output logic [DW-1:0] to_core_data
);
  import dxc_pkg::*;

  chain_e        chain;
  logic          rdy;
  logic          itr_so, dtr_so;
  logic [DW-1:0] itr_q;
  logic          itr_loaded;
  logic          dtr_full;

  assign chain = pick_chain(sel_itr, sel_dtr);

  dxc_itr_chain #(.DW(DW)) u_itr (
    .clk(clk), .rst(rst), .act(chain == CH_ITR),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr),
    .tdi(tdi), .rdy(rdy), .so(itr_so), .itr_q(itr_q), .loaded(itr_loaded)
  );

  dxc_dtr_chain #(.DW(DW)) u_dtr (
    .clk(clk), .rst(rst), .act(chain == CH_DTR), .mode_wr(mode_wr),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr),
    .tdi(tdi), .rdy(rdy), .core_wr_vld(core_wr_vld),
    .core_wr_data(core_wr_data), .so(dtr_so), .to_core(to_core_data),
    .full(dtr_full)
  );

  dxc_issue_ctrl #(.DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .in_idle(in_idle), .exec_en(exec_en),
    .chain_act(chain != CH_NONE), .itr_loaded(itr_loaded), .itr_op(itr_q),
    .core_done(core_done), .rdy(rdy), .issue(issue), .issue_op(issue_op)
  );

  always_comb begin
    case (chain)
      CH_ITR:  tdo = itr_so;
      CH_DTR:  tdo = dtr_so;
      default: tdo = 1'b0;
    endcase
  end

  p_ready_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (rdy && !issue && !dtr_full));
endmodule

// File: tb/test_dbg_xfer_chains.sv
module test_dbg_xfer_chains;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_itr = 0, sel_dtr = 0, mode_wr = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, in_idle = 0, tdi = 0;
  logic exec_en = 1;
  logic core_done = 0, core_wr_vld = 0;
  logic [DW-1:0] core_wr_data = '0;
  logic tdo, issue;
  logic [DW-1:0] issue_op, to_core_data;

  int n_chk = 0, n_fail = 0;
  int n_issue = 0;
  logic [DW-1:0] last_op = '0;
  int busy_len = 3;
  int busy_cnt = 0;
  bit produce = 0;

  always #10 clk = ~clk;

  dbg_xfer_chains #(.DW(DW)) i_dbg_xfer_chains (
    .clk(clk), .rst(rst), .sel_itr(sel_itr), .sel_dtr(sel_dtr),
    .mode_wr(mode_wr), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .in_idle(in_idle), .tdi(tdi), .tdo(tdo),
    .exec_en(exec_en), .core_done(core_done), .core_wr_vld(core_wr_vld),
    .core_wr_data(core_wr_data), .issue(issue), .issue_op(issue_op),
    .to_core_data(to_core_data)
  );

  // core model: answers each issue after busy_len cycles
  always @(negedge clk) begin
    core_done   = 1'b0;
    core_wr_vld = 1'b0;
    if (issue) begin
      n_issue++;
      last_op  = issue_op;
      busy_cnt = busy_len;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        core_done = 1'b1;
        if (produce) begin
          core_wr_vld  = 1'b1;
          core_wr_data = last_op ^ 32'h5A5A_0000;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input bit itr, input bit wr, input logic [33:0] din,
                      input int n, input int idle, output logic [33:0] dout);
    dout = '0;
    @(negedge clk);
    sel_itr = itr; sel_dtr = !itr; mode_wr = wr; capture_dr = 1;
    @(negedge clk);
    capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = din[i]; dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk);
    update_dr = 0;
    if (idle > 0) begin
      in_idle = 1;
      repeat (idle) @(negedge clk);
      in_idle = 0;
      @(negedge clk);
    end
  endtask

  task automatic idle_visit(input int cyc);
    @(negedge clk);
    in_idle = 1;
    repeat (cyc) @(negedge clk);
    in_idle = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(tdo == 0, "R1 tdo", tdo, 0);
    chk(issue == 0, "R1 issue", issue, 0);
    chk(to_core_data == 0, "R1 to_core_data", to_core_data, 0);
  endtask

  task automatic t_itr_issue;
    logic [33:0] d;
    int n0;
    n0 = n_issue;
    scan(1, 1, 34'h0_1234_5678, 33, 4, d);
    chk(d[31:0] == 0, "R2 capture data zeros", d[31:0], 0);
    chk(d[32] == 1, "R2 R1 ready bit at position DW", d[32], 1);
    chk(n_issue == n0 + 1, "R5 single issue over 4 idle cycles", n_issue - n0, 1);
    chk(last_op == 32'h1234_5678, "R4 issued opcode", last_op, 32'h1234_5678);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_busy_gate;
    logic [33:0] d;
    int n0;
    busy_len = 300;
    scan(1, 1, 34'h0_AAAA_0001, 33, 2, d);
    n0 = n_issue;
    scan(1, 1, 34'h0_BBBB_0002, 33, 0, d);
    chk(d[32] == 0, "R4 ready low while busy", d[32], 0);
    repeat (320) @(negedge clk);
    scan(1, 1, 34'h0, 33, 0, d);
    chk(d[32] == 1, "R4 ready set after completion", d[32], 1);
    busy_len = 3;
  endtask

  task automatic t_rejected_load;
    logic [33:0] d;
    busy_len = 300;
    scan(1, 1, 34'h0_C0DE_0003, 33, 2, d);
    scan(1, 1, 34'h0_DEAD_0004, 33, 0, d);
    repeat (320) @(negedge clk);
    busy_len = 3;
    idle_visit(2);
    chk(last_op == 32'hC0DE_0003, "R3 load ignored when ready was low", last_op, 32'hC0DE_0003);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_exec_off;
    logic [33:0] d;
    int n0;
    n0 = n_issue;
    exec_en = 0;
    scan(1, 1, 34'h0_0000_0F0F, 33, 3, d);
    chk(n_issue == n0, "R6 no issue with exec disabled", n_issue - n0, 0);
    exec_en = 1;
    idle_visit(2);
    chk(n_issue == n0 + 1 && last_op == 32'h0000_0F0F, "R6 issue after enable", last_op, 32'h0000_0F0F);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_no_chain;
    int n0;
    n0 = n_issue;
    @(negedge clk);
    sel_itr = 0; sel_dtr = 0;
    idle_visit(3);
    chk(n_issue == n0, "R11 no issue without chain", n_issue - n0, 0);
  endtask

  task automatic t_write_stream;
    logic [33:0] d;
    int n0;
    scan(1, 1, 34'h0_7777_0005, 33, 0, d);
    n0 = n_issue;
    scan(0, 1, 34'h0_1111_2222, 34, 2, d);
    chk(to_core_data == 32'h1111_2222, "R7 word written", to_core_data, 32'h1111_2222);
    chk(d[31:0] == 0 && d[33:32] == 2'b11, "R8 write-mode capture", d, 34'h3_0000_0000);
    chk(n_issue == n0 + 1 && last_op == 32'h7777_0005, "R10 issue per word", n_issue - n0, 1);
    repeat (10) @(negedge clk);
    scan(0, 1, 34'h0_3333_4444, 34, 2, d);
    chk(n_issue == n0 + 2 && last_op == 32'h7777_0005, "R10 reissue second word", n_issue - n0, 2);
    repeat (10) @(negedge clk);
    busy_len = 300;
    scan(0, 1, 34'h0_5555_6666, 34, 2, d);
    scan(0, 1, 34'h0_9999_9999, 34, 0, d);
    chk(d[32] == 0, "R7 ready low reported", d[32], 0);
    chk(to_core_data == 32'h5555_6666, "R7 no write when ready low", to_core_data, 32'h5555_6666);
    repeat (320) @(negedge clk);
    busy_len = 3;
  endtask

  task automatic t_read_back;
    logic [33:0] d;
    produce = 1;
    scan(1, 1, 34'h0_0000_00AB, 33, 2, d);
    repeat (10) @(negedge clk);
    produce = 0;
    scan(0, 0, 34'h3_FFFF_FFFF, 34, 0, d);
    chk(d[31:0] == (32'h0000_00AB ^ 32'h5A5A_0000), "R8 core word read", d[31:0], 32'h5A5A_00AB);
    chk(d[32] == 1, "R9 full reported", d[32], 1);
    chk(d[33] == 1, "R8 retry-status bit", d[33], 1);
    chk(to_core_data == 32'h5555_6666, "R7 read-mode update ignored", to_core_data, 32'h5555_6666);
    scan(0, 0, 34'h0, 34, 0, d);
    chk(d[32] == 0, "R9 full cleared by read capture", d[32], 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_itr_issue;
        t_busy_gate;
        t_rejected_load;
        t_exec_off;
        t_no_chain;
        t_write_stream;
        t_read_back;
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule